// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a 32-bit processor core that does not overlap instructions. Each instruction passes through a fixed series of steps, one per clock when memory is ready: fetch, decode with register read, execute or address calculation, memory access or branch resolution, and register write-back. Between steps it keeps its partial results in dedicated registers: the program counter, the next sequential address, the instruction word, two operand registers, the extended immediate, the execute result, the branch condition and the loaded word. It has thirty-two general registers.

All instruction fetches and data accesses go over one word-addressed request port that uses valid/ready. The core raises `mem_req_valid` in the fetch step, and in the memory step of a load or store. The request is accepted on a cycle where `mem_req_ready` is high. While ready is low the core holds valid, address, write flag and write data unchanged and stays in the same step, so memory can stall the core for as long as it needs. The memory returns read data on `mem_rsp_data` in the same cycle that it accepts a read, and it commits a write on the clock edge that ends the accepting cycle. The port carries byte address bits [ADDR_W+1:2].

Instruction fields are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], and a 16-bit immediate [15:0]. The core pulses `retire` during the last cycle of each instruction.

Top module: `mcpu_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pc_o` is 0 and the core requests a read (`mem_req_write` low) at word address 0.
- R2: A fetch reads the word at `pc_o[ADDR_W+1:2]` as the instruction. The next sequential address is the PC plus 4.
- R3: While `mem_req_valid` is high and `mem_req_ready` is low, the core does not advance, and in the next cycle it presents the same valid, address, write flag and write data. Results do not depend on how long memory stalls.
- R4: Opcode 0x00 is a register-register operation whose result is written to rd. The function codes are 0x20 add, 0x22 subtract (rs minus rt), 0x24 and, 0x25 or, 0x26 xor, and 0x2A signed set-less-than, which gives 1 or 0.
- R5: The register-immediate opcodes are 0x08 add, 0x0C and, 0x0D or and 0x0A signed set-less-than. Each uses rs and the sign-extended immediate, and writes its result to rt.
- R6: Load word (opcode 0x23) reads memory at byte address rs + sign-extended immediate and writes the word to rt.
- R7: Store word (opcode 0x2B) writes register rt to memory at byte address rs + sign-extended immediate.
- R8: Branch-if-zero (opcode 0x04) tests rs. If rs is zero, the next PC is PC + 4 + (immediate << 2). Otherwise it is PC + 4.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: When memory is always ready, a load or an ALU operation takes 5 cycles, a store or a branch takes 4, and an undefined encoding takes 2.
- R11: An undefined opcode, or opcode 0x00 with an undefined function code, changes no register and no memory, and execution continues at PC + 4.
- R12: `retire` is high for exactly one cycle per instruction, in its last cycle. The cycle after `retire` is a fetch step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Word address |
| mem_req_wdata | output | XLEN | Store data |
| mem_rsp_data | input | XLEN | Read data, valid in the accepting cycle of a read |
| retire | output | 1 | Last cycle of an instruction |
| pc_o | output | XLEN | Current program counter |

## Verification
A stored word reaches memory on the clock edge that ends the store's memory step. A register result can only be seen through a later store. The PC after a branch is visible from the first cycle after that branch's memory step. The bench samples every output at the falling edge. It timestamps each `retire` pulse and compares the spacing of consecutive pulses with the length R10 gives for each instruction. It compares memory and the final `pc_o` only after the closing self-loop branch has retired as often as the bench's own instruction-level model predicts. Stalls from random `mem_req_ready` therefore move the timing without changing what is compared.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

  typedef enum logic [2:0] {ST_IF, ST_ID, ST_EX, ST_MEM, ST_WB} step_e;
  typedef enum logic [2:0] {CL_RR, CL_RI, CL_LW, CL_SW, CL_BZ, CL_NOP} iclass_e;
  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT} aluop_e;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_BZ   = 6'h04;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_SLTI = 6'h0A;
  localparam logic [5:0] OP_ANDI = 6'h0C;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    iclass_e cls;
    aluop_e  op;
  } dec_t;

  function automatic dec_t decode(logic [31:0] ir);
    dec_t d;
    d.cls = CL_NOP;
    d.op  = ALU_ADD;
    case (ir[31:26])
      OP_REG: begin
        d.cls = CL_RR;
        case (ir[5:0])
          FN_ADD:  d.op = ALU_ADD;
          FN_SUB:  d.op = ALU_SUB;
          FN_AND:  d.op = ALU_AND;
          FN_OR:   d.op = ALU_OR;
          FN_XOR:  d.op = ALU_XOR;
          FN_SLT:  d.op = ALU_SLT;
          default: d.cls = CL_NOP;
        endcase
      end
      OP_ADDI: begin d.cls = CL_RI; d.op = ALU_ADD; end
      OP_ANDI: begin d.cls = CL_RI; d.op = ALU_AND; end
      OP_ORI:  begin d.cls = CL_RI; d.op = ALU_OR;  end
      OP_SLTI: begin d.cls = CL_RI; d.op = ALU_SLT; end
      OP_LW:   d.cls = CL_LW;
      OP_SW:   d.cls = CL_SW;
      OP_BZ:   d.cls = CL_BZ;
      default: d.cls = CL_NOP;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mcpu_alu.sv
module mcpu_alu
  import mcpu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  aluop_e            op,
  input  logic [XLEN-1:0]   lhs,
  input  logic [XLEN-1:0]   rhs,
  output logic [XLEN-1:0]   res
);

  always_comb begin
    case (op)
      ALU_SUB: res = lhs - rhs;
      ALU_AND: res = lhs & rhs;
      ALU_OR:  res = lhs | rhs;
      ALU_XOR: res = lhs ^ rhs;
      ALU_SLT: res = XLEN'($signed(lhs) < $signed(rhs));
      default: res = lhs + rhs;
    endcase
  end

endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NREG)-1:0]  rd_a_idx,
  input  logic [$clog2(NREG)-1:0]  rd_b_idx,
  output logic [XLEN-1:0]          rd_a_val,
  output logic [XLEN-1:0]          rd_b_val,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_idx,
  input  logic [XLEN-1:0]          wr_val
);

  localparam int IW = $clog2(NREG);

  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs[g] <= '0;
        else if (wr_en && wr_idx == IW'(g))
          regs[g] <= wr_val;
      end
    end
  end

  assign rd_a_val = regs[rd_a_idx];
  assign rd_b_val = regs[rd_b_idx];

endmodule

// File: rtl/mcpu_seq.sv
module mcpu_seq
  import mcpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  iclass_e cls,
  input  logic    mem_ready,
  output step_e   step,
  output logic    need_mem,
  output logic    advance,
  output logic    retire
);

  step_e step_nxt;

  always_comb begin
    need_mem = (step == ST_IF) ||
               (step == ST_MEM && (cls == CL_LW || cls == CL_SW));
    advance  = !need_mem || mem_ready;
    case (step)
      ST_IF:   step_nxt = ST_ID;
      ST_ID:   step_nxt = (cls == CL_NOP) ? ST_IF : ST_EX;
      ST_EX:   step_nxt = ST_MEM;
      ST_MEM:  step_nxt = (cls == CL_SW || cls == CL_BZ) ? ST_IF : ST_WB;
      default: step_nxt = ST_IF;
    endcase
    retire = advance && ((step == ST_WB) ||
                         (step == ST_MEM && (cls == CL_SW || cls == CL_BZ)) ||
                         (step == ST_ID && cls == CL_NOP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      step <= ST_IF;
    else if (advance)
      step <= step_nxt;
  end

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
  import mcpu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NREG   = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [XLEN-1:0]   mem_req_wdata,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              retire,
  output logic [XLEN-1:0]   pc_o
);

  localparam int IW   = $clog2(NREG);
  localparam int IMMW = 16;

  logic [XLEN-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, alu_q, lmd_q;
  logic            cond_q;

  step_e   cur_step;
  dec_t    dec;
  logic    need_mem, advance;
  aluop_e  alu_op;
  logic [XLEN-1:0] alu_lhs, alu_rhs, alu_res;
  logic [XLEN-1:0] rs_val, rt_val, imm_ext;
  logic [IW-1:0]   rs_idx, rt_idx, rd_idx, wr_idx;
  logic [XLEN-1:0] wr_val;
  logic            wr_en;

  assign dec     = decode(ir_q);
  assign rs_idx  = IW'(ir_q[25:21]);
  assign rt_idx  = IW'(ir_q[20:16]);
  assign rd_idx  = IW'(ir_q[15:11]);
  assign imm_ext = {{(XLEN-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};

  mcpu_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cls       (dec.cls),
    .mem_ready (mem_req_ready),
    .step      (cur_step),
    .need_mem  (need_mem),
    .advance   (advance),
    .retire    (retire)
  );

  mcpu_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (rs_idx),
    .rd_b_idx (rt_idx),
    .rd_a_val (rs_val),
    .rd_b_val (rt_val),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_val   (wr_val)
  );

  // one adder/logic unit serves addresses, ALU ops and branch targets
  always_comb begin
    alu_op  = ALU_ADD;
    alu_lhs = a_q;
    alu_rhs = imm_q;
    case (dec.cls)
      CL_RR: begin alu_op = dec.op; alu_rhs = b_q; end
      CL_RI: alu_op = dec.op;
      CL_BZ: begin alu_lhs = npc_q; alu_rhs = {imm_q[XLEN-3:0], 2'b00}; end
      default: ;
    endcase
  end

  mcpu_alu #(.XLEN(XLEN)) u_alu (
    .op  (alu_op),
    .lhs (alu_lhs),
    .rhs (alu_rhs),
    .res (alu_res)
  );

  assign mem_req_valid = need_mem;
  assign mem_req_write = (cur_step == ST_MEM) && (dec.cls == CL_SW);
  assign mem_req_addr  = (cur_step == ST_IF) ? pc_q[ADDR_W+1:2] : alu_q[ADDR_W+1:2];
  assign mem_req_wdata = b_q;

  assign wr_en  = (cur_step == ST_WB);
  assign wr_idx = (dec.cls == CL_RR) ? rd_idx : rt_idx;
  assign wr_val = (dec.cls == CL_LW) ? lmd_q : alu_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      npc_q  <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      imm_q  <= '0;
      alu_q  <= '0;
      lmd_q  <= '0;
      cond_q <= 1'b0;
    end else if (advance) begin
      case (cur_step)
        ST_IF: begin
          ir_q  <= mem_rsp_data;
          npc_q <= pc_q + XLEN'(4);
        end
        ST_ID: begin
          a_q   <= rs_val;
          b_q   <= rt_val;
          imm_q <= imm_ext;
          if (dec.cls == CL_NOP) pc_q <= npc_q;
        end
        ST_EX: begin
          alu_q  <= alu_res;
          cond_q <= (a_q == '0);
        end
        ST_MEM: begin
          pc_q <= (dec.cls == CL_BZ && cond_q) ? alu_q : npc_q;
          if (dec.cls == CL_LW) lmd_q <= mem_rsp_data;
        end
        default: ;
      endcase
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/mcpu_core_chk.sv
module mcpu_core_chk
  import mcpu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        step,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [XLEN-1:0]   mem_req_wdata,
  input logic              retire,
  input logic [XLEN-1:0]   pc_o
);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  p_fetch_at_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_IF) |-> (mem_req_valid && !mem_req_write && mem_req_addr == pc_o[ADDR_W+1:2]));

  p_write_in_mem_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (step == ST_MEM));

  p_pc_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[1:0] == 2'b00);

  p_pc_moves_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc_o) |-> ($past(step) == ST_MEM || $past(step) == ST_ID));

  p_fetch_after_retire_r12: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (step == ST_IF));

  p_retire_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire);

endmodule

bind mcpu_core mcpu_core_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .step          (cur_step),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .retire        (retire),
  .pc_o          (pc_o)
);

// File: tb/mcpu_core_tb.sv
module mcpu_core_tb;

  localparam int XLEN   = 32;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mem_req_valid, mem_req_write, retire;
  logic              mem_req_ready = 1'b1;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [XLEN-1:0]   mem_req_wdata, mem_rsp_data, pc_o;

  logic [31:0] mem   [256];
  logic [31:0] prog  [128];
  logic [31:0] m_mem [256];
  logic [31:0] m_reg [32];
  int          exp_dur [2048];
  int          rt_time [2048];
  int          rt_cnt = 0;
  int          cyc = 0;
  int          plen, n_exec, halt_pc;
  int          n_chk = 0, n_pass = 0;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  bit          rnd_ready = 1'b0;

  localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFF};

  always #10 clk = ~clk;

  mcpu_core #(.XLEN(XLEN), .NREG(32), .ADDR_W(ADDR_W)) u_dut (
    .clk, .rst_n, .mem_req_valid, .mem_req_ready, .mem_req_write,
    .mem_req_addr, .mem_req_wdata, .mem_rsp_data, .retire, .pc_o
  );

  assign mem_rsp_data = mem[mem_req_addr[7:0]];

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_req_valid && mem_req_ready && mem_req_write)
      mem[mem_req_addr[7:0]] <= mem_req_wdata;
  end

  always @(negedge clk) begin
    mem_req_ready <= rnd_ready ? (($urandom % 4) != 0) : 1'b1;
    if (!rst_n) begin
      rt_cnt <= 0;
      cyc    <= 0;
    end else begin
      cyc <= cyc + 1;
      if (retire && rt_cnt < 2048) begin
        rt_time[rt_cnt] <= cyc;
        rt_cnt <= rt_cnt + 1;
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (ok) n_pass++;
    else $display("FAIL %s got=%h exp=%h", req, got, exp);
  endtask

  function automatic logic [31:0] enc_r(logic [5:0] fn, int rd, int rs, int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rt, int rs, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic emit(logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask

  // instruction-level model built from the requirements
  task automatic run_model();
    int pc = 0;
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    for (int i = 0; i < 256; i++) m_mem[i] = (i < plen) ? prog[i] : 32'h0;
    n_exec = 0;
    for (int s = 0; s < 2000; s++) begin
      logic [31:0] w, a, b, sx, ea, res;
      int nxt, d;
      bit wr;
      int dst;
      w  = m_mem[(pc >> 2) & 255];
      a  = m_reg[w[25:21]];
      b  = m_reg[w[20:16]];
      sx = {{16{w[15]}}, w[15:0]};
      ea = a + sx;
      nxt = pc + 4;
      wr = 1'b0; dst = 0; res = '0; d = 2;
      case (w[31:26])
        6'h00: begin
          wr = 1'b1; dst = int'(w[15:11]); d = 5;
          case (w[5:0])
            6'h20: res = a + b;
            6'h22: res = a - b;
            6'h24: res = a & b;
            6'h25: res = a | b;
            6'h26: res = a ^ b;
            6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: begin wr = 1'b0; d = 2; end
          endcase
        end
        6'h08: begin wr = 1'b1; dst = int'(w[20:16]); d = 5; res = a + sx; end
        6'h0C: begin wr = 1'b1; dst = int'(w[20:16]); d = 5; res = a & sx; end
        6'h0D: begin wr = 1'b1; dst = int'(w[20:16]); d = 5; res = a | sx; end
        6'h0A: begin wr = 1'b1; dst = int'(w[20:16]); d = 5;
                     res = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; end
        6'h23: begin wr = 1'b1; dst = int'(w[20:16]); d = 5; res = m_mem[(ea >> 2) & 255]; end
        6'h2B: begin d = 4; m_mem[(ea >> 2) & 255] = b; end
        6'h04: begin d = 4; if (a == 0) nxt = nxt + int'({sx[29:0], 2'b00}); end
        default: d = 2;
      endcase
      if (wr && dst != 0) m_reg[dst] = res;
      exp_dur[n_exec] = d;
      n_exec++;
      if (w == HALT) begin
        halt_pc = pc;
        break;
      end
      pc = nxt;
    end
  endtask

  task automatic run_dut(bit rnd);
    rst_n = 1'b0;
    rnd_ready = 1'b0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_en = 1'b1;
      ld_addr = 8'(i);
      ld_data = (i < plen) ? prog[i] : 32'h0;
    end
    @(negedge clk);
    ld_en = 1'b0;
    // R1: reset state seen at the ports
    chk(pc_o == 32'h0, "R1 pc in reset", pc_o, 32'h0);
    chk(mem_req_valid && !mem_req_write && mem_req_addr == '0, "R1 first fetch at word 0",
        {15'd0, mem_req_valid, mem_req_addr}, 32'h0001_0000);
    rst_n = 1'b1;
    rnd_ready = rnd;
    begin
      int w = 0;
      while (rt_cnt < n_exec && w < 30000) begin
        @(negedge clk);
        w++;
      end
      chk(rt_cnt >= n_exec, "R12 watchdog: retire count reached", 32'(rt_cnt), 32'(n_exec));
    end
    rnd_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));

    // ---------- directed program ----------
    plen = 0;
    emit(enc_i(6'h08, 1, 0, 16'd5));        // r1 = 5
    emit(enc_i(6'h08, 2, 0, 16'hFFFD));     // r2 = -3
    emit(enc_r(6'h20, 3, 1, 2));            // r3 = 2
    emit(enc_r(6'h22, 4, 1, 2));            // r4 = 8
    emit(enc_r(6'h2A, 9, 2, 1));            // r9 = 1
    emit(enc_i(6'h2B, 3, 0, 16'h0200));     // mem[128] = r3
    emit(enc_i(6'h23, 5, 0, 16'h0200));     // r5 = mem[128]
    emit(enc_i(6'h04, 0, 0, 16'd1));        // taken, skips next
    emit(enc_i(6'h08, 6, 0, 16'd99));
    emit(enc_i(6'h04, 0, 1, 16'd5));        // not taken
    emit(enc_i(6'h08, 7, 0, 16'd11));       // r7 = 11
    emit(32'hFC00_0000);                    // undefined opcode
    emit(enc_r(6'h3F, 8, 1, 1));            // undefined function
    emit(enc_i(6'h08, 0, 0, 16'd7));        // write to r0
    emit(enc_r(6'h20, 10, 0, 1));           // r10 = r0 + r1
    emit(enc_i(6'h2B, 4, 0, 16'h0204));
    emit(enc_i(6'h2B, 5, 0, 16'h0208));
    emit(enc_i(6'h2B, 6, 0, 16'h020C));
    emit(enc_i(6'h2B, 7, 0, 16'h0210));
    emit(enc_i(6'h2B, 0, 0, 16'h0214));
    emit(enc_i(6'h2B, 9, 0, 16'h0218));
    emit(enc_i(6'h2B, 10, 0, 16'h021C));
    emit(enc_i(6'h2B, 8, 0, 16'h0220));
    emit(HALT);
    run_model();
    run_dut(1'b0);
    chk(mem[128] == 32'd2, "R7 store of add result", mem[128], 32'd2);
    chk(mem[129] == 32'd8, "R4 subtract", mem[129], 32'd8);
    chk(mem[130] == 32'd2, "R6 load", mem[130], 32'd2);
    chk(mem[131] == 32'd0, "R8 taken branch skips", mem[131], 32'd0);
    chk(mem[132] == 32'd11, "R8 not-taken falls through", mem[132], 32'd11);
    chk(mem[133] == 32'd0, "R9 r0 write ignored", mem[133], 32'd0);
    chk(mem[134] == 32'd1, "R4 signed slt", mem[134], 32'd1);
    chk(mem[135] == 32'd5, "R9 r0 reads zero", mem[135], 32'd5);
    chk(mem[136] == 32'd0, "R11 undefined funct no write", mem[136], 32'd0);
    chk(pc_o == 32'(halt_pc), "R8 final pc at self-loop", pc_o, 32'(halt_pc));
    for (int k = 1; k < n_exec; k++)
      chk(rt_time[k] - rt_time[k-1] == exp_dur[k], "R10 R12 cycles per instruction",
          32'(rt_time[k] - rt_time[k-1]), 32'(exp_dur[k]));

    // ---------- random program under random stalls ----------
    plen = 0;
    for (int r = 1; r < 32; r++) emit(enc_i(6'h08, r, 0, 16'($urandom)));
    for (int n = 0; n < 48; n++) begin
      int sel = int'($urandom % 14);
      int rd  = int'($urandom % 32);
      int rs  = int'($urandom % 32);
      int rt  = int'($urandom % 32);
      logic [5:0] fns [6] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A};
      logic [5:0] ops [4] = '{6'h08, 6'h0C, 6'h0D, 6'h0A};
      if (sel < 6)        emit(enc_r(fns[sel], rd, rs, rt));
      else if (sel < 10)  emit(enc_i(ops[sel-6], rt, rs, 16'($urandom)));
      else if (sel == 10) emit(enc_i(6'h2B, rt, 0, 16'(32'h200 + 4 * (n % 32))));
      else if (sel == 11) emit(enc_i(6'h23, rt, 0, 16'(32'h200 + 4 * (n % 32))));
      else if (sel == 12) emit(32'hE800_0000 | 32'($urandom % 65536));
      else                emit(enc_i(6'h04, 0, rs, 16'd1));
    end
    for (int r = 0; r < 32; r++) emit(enc_i(6'h2B, r, 0, 16'(32'h280 + 4 * r)));
    emit(HALT);
    run_model();
    run_dut(1'b1);
    for (int i = 128; i < 192; i++)
      chk(mem[i] == m_mem[i], "R3 R4 R5 R6 R7 R9 R11 data word vs model", mem[i], m_mem[i]);
    chk(pc_o == 32'(halt_pc), "R2 R8 final pc", pc_o, 32'(halt_pc));

    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end

  initial begin
    #(20 * 190000);
    n_chk++;
    $display("FAIL R12 watchdog expired got=%0d exp=%0d", rt_cnt, n_exec);
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end

endmodule